// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Controller

This block connects an internal word-request port to an external asynchronous parallel bus for SRAM, EEPROM or NOR flash. The bus has separate address and data pins. A request carries an address, write data, a direction flag, byte enables and a burst length. The request is accepted with a valid/ready handshake and is then played out on the pins under registered control. Every completed word produces a one-cycle response pulse. On reads, the captured data comes with that pulse.

A single access has three parts. First comes a one-cycle address phase, with chip select active and both strobes idle. Next comes a data phase of one cycle plus the programmed wait states, with the read or write strobe asserted. Last comes a closing cycle. In that cycle chip select is released, while a write keeps its address and data driven. After the closing cycle the controller returns to idle.

In continuous-read mode the controller holds the read strobe low for a whole burst. It steps the address by one after each captured word, which suits fast sequential SRAM reads. A two-bit chip-select setting chooses one of two schemes. The first is a plain single chip select. The second adds an address-latch pulse and splits the space over two chip selects by the top address bit. Writes to flash are plain bus writes. No command sequencing is generated.

Top module: `hbus_ctrl`

## Requirements
- R1: After reset, both chip selects, the read strobe and the write strobe are high (inactive), the latch pulse is low, the data drive enable is low, rsp_valid is low, req_ready is high, and all byte selects are high.
- R2: An accepted request is followed by exactly one address-phase cycle. In that cycle chip select is low and both strobes are high. Chip select stays low in every cycle in which the read or write strobe is low.
- R3: For a single read, the read strobe is low for 1 + cfg_rd_ws cycles. rsp_valid pulses for one cycle, 3 + cfg_rd_ws cycles after the accepting clock edge. rsp_rdata then holds the bus data sampled at the last strobe cycle. The read and write strobes are never low together.
- R4: For a write, the write strobe is low for 1 + cfg_wr_ws cycles. rsp_valid pulses 3 + cfg_wr_ws cycles after the accepting edge. The data drive enable is high from the address phase through the closing cycle.
- R5: In the cycle after a write strobe ends, chip select is already high, while bus_addr, bus_dout and bus_doe keep their write values.
- R6: When cfg_bsel_en is 1, bus_bsel_n equals the inverted req_be, where bit i selects data byte i. When cfg_bsel_en is 0, bus_bsel_n is all ones. The byte selects change only at the clock edge that accepts a request, which is when the address changes.
- R7: With cfg_cs_mode = 2'b11, bus_ale is high during the address phase only. In this mode bus_cs1_n is used when the top address bit is 1 and bus_cs0_n otherwise. Any other value uses bus_cs0_n alone and keeps bus_ale low. The two chip selects are never low together.
- R8: With cfg_cont_en = 1, a read of req_len words (0 counts as 1) keeps the read strobe low throughout. Word k arrives 3 + cfg_rd_ws + k*(1 + cfg_rd_ws) cycles after acceptance, with data from the start address plus k. The address steps by one only after a capture. The strobe rises after the last word.
- R9: req_ready is high only in idle. Between two accesses there is at least one cycle in which both chip selects and both strobes are inactive. rsp_valid is never high while req_ready is high.
- R10: A write, or a read with cfg_cont_en = 0, transfers exactly one word whatever req_len holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | DATA_W/8 | Byte enables, bit i = byte i |
| req_len | input | LEN_W | Burst word count for continuous reads |
| cfg_rd_ws | input | WS_W | Read wait states |
| cfg_wr_ws | input | WS_W | Write wait states |
| cfg_cont_en | input | 1 | Continuous-read enable |
| cfg_cs_mode | input | 2 | 2'b11 latch + dual select, else plain select |
| cfg_bsel_en | input | 1 | Byte-select outputs enable |
| rsp_valid | output | 1 | One-cycle completion pulse per word |
| rsp_rdata | output | DATA_W | Read data |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External write data |
| bus_doe | output | 1 | Data pin drive enable |
| bus_din | input | DATA_W | External read data |
| bus_bsel_n | output | DATA_W/8 | Byte selects, active low |
| bus_cs0_n | output | 1 | Chip select 0, active low |
| bus_cs1_n | output | 1 | Chip select 1, active low |
| bus_ale | output | 1 | Address latch pulse |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |

## Verification
The bench uses the default parameters: a 20-bit address, a 16-bit data bus and 4-bit wait counts. The 16-bit bus gives two byte lanes, so the byte-select inversion can be told apart from a pass-through. With a 20-bit address, the top address bit 19 can be set, so a read at 0x80005 moves the access onto the second chip select. Wait counts of 0 to 5 are used for both directions, so latency and strobe width vary. Continuous bursts of four words, and a zero-length burst, exercise the address stepping and the length floor.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [2:0] {
    HB_IDLE,
    HB_ADDR,
    HB_DATA,
    HB_CONT,
    HB_CLOSE
  } hb_state_t;

  localparam logic [1:0] HB_CS_LATCH_DUAL = 2'b11;
endpackage

// File: rtl/hbus_wait_ctr.sv
module hbus_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit);
endmodule

// File: rtl/hbus_strobe_gen.sv
module hbus_strobe_gen
  import hbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  hb_state_t  st_d,
  input  logic       wr_d,
  input  logic       hi_d,
  input  logic [1:0] cs_mode,
  output logic       cs0_n,
  output logic       cs1_n,
  output logic       ale,
  output logic       oe_n,
  output logic       we_n
);
  logic dual, cs_on, strobe_on;

  always_comb begin
    dual      = (cs_mode == HB_CS_LATCH_DUAL);
    cs_on     = (st_d == HB_ADDR) || (st_d == HB_DATA) || (st_d == HB_CONT);
    strobe_on = (st_d == HB_DATA) || (st_d == HB_CONT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs0_n <= 1'b1;
      cs1_n <= 1'b1;
      ale   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
    end else begin
      cs0_n <= !(cs_on && !(dual && hi_d));
      cs1_n <= !(cs_on && dual && hi_d);
      ale   <= dual && (st_d == HB_ADDR);
      oe_n  <= !(strobe_on && !wr_d);
      we_n  <= !(strobe_on && wr_d && (st_d == HB_DATA));
    end
  end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter  int ADDR_W = 20,
  parameter  int DATA_W = 16,
  parameter  int WS_W   = 4,
  parameter  int LEN_W  = 8,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [WS_W-1:0]   cfg_rd_ws,
  input  logic [WS_W-1:0]   cfg_wr_ws,
  input  logic              cfg_cont_en,
  input  logic [1:0]        cfg_cs_mode,
  input  logic              cfg_bsel_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic [BE_W-1:0]   bus_bsel_n,
  output logic              bus_cs0_n,
  output logic              bus_cs1_n,
  output logic              bus_ale,
  output logic              bus_oe_n,
  output logic              bus_we_n
);
  hb_state_t         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dout_q, dout_d, rdata_q, rdata_d;
  logic [BE_W-1:0]   bsel_q, bsel_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              wr_q, wr_d, cont_q, cont_d, doe_q, doe_d, rsp_q, rsp_d;
  logic              wclr, wen, wdone;
  logic [WS_W-1:0]   wlim;

  assign wlim = wr_q ? cfg_wr_ws : cfg_rd_ws;

  hbus_wait_ctr #(.W(WS_W)) u_wait (
    .clk   (clk),
    .rst   (rst),
    .clr   (wclr),
    .en    (wen),
    .limit (wlim),
    .done  (wdone)
  );

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    dout_d  = dout_q;
    rdata_d = rdata_q;
    bsel_d  = bsel_q;
    rem_d   = rem_q;
    wr_d    = wr_q;
    cont_d  = cont_q;
    doe_d   = doe_q;
    rsp_d   = 1'b0;
    wclr    = 1'b0;
    wen     = 1'b0;
    unique case (st_q)
      HB_IDLE: begin
        if (req_valid) begin
          st_d   = HB_ADDR;
          addr_d = req_addr;
          dout_d = req_wdata;
          wr_d   = req_write;
          doe_d  = req_write;
          bsel_d = cfg_bsel_en ? ~req_be : '1;
          cont_d = cfg_cont_en && !req_write;
          rem_d  = (req_len == '0) ? LEN_W'(1) : req_len;
        end
      end
      HB_ADDR: begin
        st_d = cont_q ? HB_CONT : HB_DATA;
        wclr = 1'b1;
      end
      HB_DATA: begin
        if (wdone) begin
          st_d  = HB_CLOSE;
          rsp_d = 1'b1;
          if (!wr_q) rdata_d = bus_din;
        end else begin
          wen = 1'b1;
        end
      end
      HB_CONT: begin
        if (wdone) begin
          rsp_d   = 1'b1;
          rdata_d = bus_din;
          wclr    = 1'b1;
          if (rem_q == LEN_W'(1)) begin
            st_d = HB_CLOSE;
          end else begin
            addr_d = addr_q + 1'b1;
            rem_d  = rem_q - 1'b1;
          end
        end else begin
          wen = 1'b1;
        end
      end
      HB_CLOSE: begin
        st_d  = HB_IDLE;
        doe_d = 1'b0;
      end
      default: st_d = HB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= HB_IDLE;
      addr_q  <= '0;
      dout_q  <= '0;
      rdata_q <= '0;
      bsel_q  <= '1;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      cont_q  <= 1'b0;
      doe_q   <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      rdata_q <= rdata_d;
      bsel_q  <= bsel_d;
      rem_q   <= rem_d;
      wr_q    <= wr_d;
      cont_q  <= cont_d;
      doe_q   <= doe_d;
      rsp_q   <= rsp_d;
    end
  end

  hbus_strobe_gen u_strobe (
    .clk     (clk),
    .rst     (rst),
    .st_d    (st_d),
    .wr_d    (wr_d),
    .hi_d    (addr_d[ADDR_W-1]),
    .cs_mode (cfg_cs_mode),
    .cs0_n   (bus_cs0_n),
    .cs1_n   (bus_cs1_n),
    .ale     (bus_ale),
    .oe_n    (bus_oe_n),
    .we_n    (bus_we_n)
  );

  assign req_ready  = (st_q == HB_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign bus_addr   = addr_q;
  assign bus_dout   = dout_q;
  assign bus_doe    = doe_q;
  assign bus_bsel_n = bsel_q;
endmodule

// File: rtl/hbus_ctrl_chk.sv
module hbus_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_doe,
  input logic [BE_W-1:0]   bus_bsel_n,
  input logic              bus_cs0_n,
  input logic              bus_cs1_n,
  input logic              bus_ale,
  input logic              bus_oe_n,
  input logic              bus_we_n
);
  assert_cs_under_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || !bus_we_n) |-> (!bus_cs0_n || !bus_cs1_n));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> bus_we_n);

  assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we_n) |-> (bus_cs0_n && bus_cs1_n && bus_doe && $stable(bus_addr) && $stable(bus_dout)));

  assert_bsel_with_addr_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_bsel_n) |-> $past(req_valid && req_ready));

  assert_single_cs_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_cs0_n |-> bus_cs1_n);

  assert_ale_addr_phase_R7: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> ((!bus_cs0_n || !bus_cs1_n) && bus_oe_n && bus_we_n));

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_addr) |-> ($past(req_valid && req_ready) || (!bus_oe_n && $past(!bus_oe_n))));

  assert_idle_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs0_n && bus_cs1_n) |=> (bus_cs0_n && bus_cs1_n && bus_oe_n && bus_we_n));

  assert_busy_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
endmodule

bind hbus_ctrl hbus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .bus_addr   (bus_addr),
  .bus_dout   (bus_dout),
  .bus_doe    (bus_doe),
  .bus_bsel_n (bus_bsel_n),
  .bus_cs0_n  (bus_cs0_n),
  .bus_cs1_n  (bus_cs1_n),
  .bus_ale    (bus_ale),
  .bus_oe_n   (bus_oe_n),
  .bus_we_n   (bus_we_n)
);

// File: tb/sim_hbus_ctrl.sv
`timescale 1ns/1ps
module sim_hbus_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic [7:0]  req_len = 8'd1;
  logic [3:0]  cfg_rd_ws = '0, cfg_wr_ws = '0;
  logic        cfg_cont_en = 1'b0, cfg_bsel_en = 1'b0;
  logic [1:0]  cfg_cs_mode = 2'b01;
  logic        rsp_valid, bus_doe, bus_cs0_n, bus_cs1_n, bus_ale, bus_oe_n, bus_we_n;
  logic [15:0] rsp_rdata, bus_dout, bus_din;
  logic [19:0] bus_addr;
  logic [1:0]  bus_bsel_n;
  logic [15:0] mem [256];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hbus_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_be(req_be), .req_len(req_len), .cfg_rd_ws(cfg_rd_ws),
    .cfg_wr_ws(cfg_wr_ws), .cfg_cont_en(cfg_cont_en), .cfg_cs_mode(cfg_cs_mode),
    .cfg_bsel_en(cfg_bsel_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_bsel_n(bus_bsel_n), .bus_cs0_n(bus_cs0_n), .bus_cs1_n(bus_cs1_n),
    .bus_ale(bus_ale), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n)
  );

  function automatic logic [15:0] init_word(input logic [7:0] a);
    return {a, ~a};
  endfunction

  assign bus_din = bus_oe_n ? 16'h0000 : mem[bus_addr[7:0]];

  always @(negedge clk)
    if (!bus_we_n && (!bus_cs0_n || !bus_cs1_n)) mem[bus_addr[7:0]] <= bus_dout;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be, input logic [7:0] len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a, input logic [3:0] ws, input logic [15:0] exp);
    int n = 1;
    int oe_low = 0;
    cfg_rd_ws = ws;
    issue(1'b0, a, 16'h0, 2'b11, 8'd1);
    chk(!bus_cs0_n && bus_oe_n && bus_we_n, "R2 address phase", {bus_cs0_n, bus_oe_n, bus_we_n}, 3'b011);
    while (!rsp_valid && n < 64) begin
      @(negedge clk); n++;
      if (!bus_oe_n) oe_low++;
    end
    chk(n == 3 + ws, "R3 read latency", n, 3 + ws);
    chk(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
    chk(oe_low == 1 + ws, "R3 strobe width", oe_low, 1 + ws);
    @(negedge clk);
    chk(!rsp_valid && req_ready && bus_cs0_n && bus_cs1_n && bus_oe_n, "R9 idle after read",
        {rsp_valid, req_ready, bus_cs0_n, bus_oe_n}, 4'b0111);
  endtask

  task automatic do_write(input logic [19:0] a, input logic [3:0] ws, input logic [15:0] d);
    int n = 1;
    int we_low = 0;
    cfg_wr_ws = ws;
    issue(1'b1, a, d, 2'b11, 8'd4);
    chk(!bus_cs0_n && bus_we_n && bus_doe, "R2 write address phase", {bus_cs0_n, bus_we_n, bus_doe}, 3'b011);
    while (!rsp_valid && n < 64) begin
      @(negedge clk); n++;
      if (!bus_we_n) we_low++;
    end
    chk(n == 3 + ws, "R4 write latency", n, 3 + ws);
    chk(we_low == 1 + ws, "R4 write strobe width", we_low, 1 + ws);
    chk(bus_cs0_n && bus_we_n && bus_doe && bus_addr == a && bus_dout == d, "R5 write hold",
        {bus_cs0_n, bus_we_n, bus_doe, bus_dout}, {3'b111, d});
    @(negedge clk);
    chk(!rsp_valid && req_ready && !bus_doe && bus_cs0_n && bus_we_n, "R10 R9 single write word",
        {rsp_valid, req_ready, bus_doe}, 3'b010);
  endtask

  localparam logic [40:0] VEC [8] = '{
    {1'b1, 20'h00010, 16'hBEEF, 4'd0},
    {1'b0, 20'h00010, 16'hBEEF, 4'd0},
    {1'b1, 20'h000FF, 16'h1234, 4'd3},
    {1'b0, 20'h000FF, 16'h1234, 4'd2},
    {1'b0, 20'h00007, 16'h07F8, 4'd1},
    {1'b1, 20'h00020, 16'h0000, 4'd5},
    {1'b0, 20'h00020, 16'h0000, 4'd0},
    {1'b0, 20'h00080, 16'h807F, 4'd4}
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_word(i[7:0]);
    repeat (3) @(negedge clk);
    chk(bus_cs0_n && bus_cs1_n && bus_oe_n && bus_we_n && !bus_ale && !bus_doe && !rsp_valid
        && req_ready && bus_bsel_n == 2'b11, "R1 reset state",
        {bus_cs0_n, bus_cs1_n, bus_oe_n, bus_we_n, bus_ale, bus_doe, rsp_valid, req_ready}, 8'b11110001);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][40]) do_write(VEC[i][39:20], VEC[i][3:0], VEC[i][19:4]);
      else            do_read(VEC[i][39:20], VEC[i][3:0], VEC[i][19:4]);
    end

    // R10: non-continuous read ignores a burst length
    begin
      int rsps = 0;
      cfg_rd_ws = 4'd0;
      issue(1'b0, 20'h00003, 16'h0, 2'b11, 8'd5);
      for (int k = 0; k < 12; k++) begin
        if (rsp_valid) rsps++;
        @(negedge clk);
      end
      chk(rsps == 1, "R10 single read word", rsps, 1);
    end

    // R8: continuous read of four words with one wait state
    begin
      int k = 0;
      int falls = 0;
      logic prev_oe = 1'b1;
      cfg_cont_en = 1'b1; cfg_rd_ws = 4'd1;
      issue(1'b0, 20'h00040, 16'h0, 2'b11, 8'd4);
      for (int n = 1; n < 16; n++) begin
        if (prev_oe && !bus_oe_n) falls++;
        prev_oe = bus_oe_n;
        if (rsp_valid) begin
          chk(n == 4 + 2 * k, "R8 burst word timing", n, 4 + 2 * k);
          chk(rsp_rdata == init_word(8'h40 + 8'(k)), "R8 burst word data", rsp_rdata, init_word(8'h40 + 8'(k)));
          k++;
          if (k == 4) chk(bus_oe_n && bus_addr == 20'h00043, "R8 strobe released at last address",
                          {bus_oe_n, bus_addr}, {1'b1, 20'h00043});
        end
        @(negedge clk);
      end
      chk(k == 4, "R8 burst word count", k, 4);
      chk(falls == 1, "R8 one strobe per burst", falls, 1);
    end

    // R8: zero length counts as one word
    begin
      int rsps = 0;
      cfg_rd_ws = 4'd0;
      issue(1'b0, 20'h00050, 16'h0, 2'b11, 8'd0);
      for (int k = 0; k < 12; k++) begin
        if (rsp_valid) begin
          rsps++;
          chk(rsp_rdata == init_word(8'h50), "R8 zero length data", rsp_rdata, init_word(8'h50));
        end
        @(negedge clk);
      end
      chk(rsps == 1, "R8 zero length word count", rsps, 1);
    end

    // R10: write with continuous mode still single word
    begin
      int rsps = 0;
      cfg_wr_ws = 4'd0;
      issue(1'b1, 20'h00060, 16'hA55A, 2'b11, 8'd3);
      for (int k = 0; k < 12; k++) begin
        if (rsp_valid) rsps++;
        @(negedge clk);
      end
      chk(rsps == 1, "R10 continuous write single word", rsps, 1);
      cfg_cont_en = 1'b0;
    end

    // R7: latch plus dual chip select
    cfg_cs_mode = 2'b11; cfg_rd_ws = 4'd0;
    issue(1'b0, 20'h80005, 16'h0, 2'b11, 8'd1);
    chk(bus_ale && !bus_cs1_n && bus_cs0_n, "R7 high half select",
        {bus_ale, bus_cs1_n, bus_cs0_n}, 3'b101);
    @(negedge clk);
    chk(!bus_ale && !bus_cs1_n && !bus_oe_n, "R7 latch only in address phase",
        {bus_ale, bus_cs1_n, bus_oe_n}, 3'b000);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 16'h05FA, "R7 dual select read data", rsp_rdata, 16'h05FA);
    issue(1'b0, 20'h00005, 16'h0, 2'b11, 8'd1);
    chk(bus_ale && !bus_cs0_n && bus_cs1_n, "R7 low half select",
        {bus_ale, bus_cs0_n, bus_cs1_n}, 3'b101);
    cfg_cs_mode = 2'b01;
    issue(1'b0, 20'h80005, 16'h0, 2'b11, 8'd1);
    chk(!bus_ale && !bus_cs0_n && bus_cs1_n, "R7 plain mode select",
        {bus_ale, bus_cs0_n, bus_cs1_n}, 3'b001);

    // R6: byte selects
    cfg_bsel_en = 1'b1; cfg_wr_ws = 4'd1;
    issue(1'b1, 20'h00070, 16'h1111, 2'b10, 8'd1);
    chk(bus_bsel_n == 2'b01, "R6 byte select at address phase", bus_bsel_n, 2'b01);
    repeat (3) @(negedge clk);
    chk(rsp_valid && bus_bsel_n == 2'b01, "R6 byte select held", bus_bsel_n, 2'b01);
    cfg_bsel_en = 1'b0;
    issue(1'b1, 20'h00071, 16'h2222, 2'b01, 8'd1);
    chk(bus_bsel_n == 2'b11, "R6 byte select disabled", bus_bsel_n, 2'b11);
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule